// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller with Lock and Flash Invalidate

This block holds the tag, valid and replacement state of a small four-way set-associative first-level cache. It decides, for each CPU access, whether the access hits, needs a burst line fill, or must go to the bus as one single-beat transfer. A three-bit control register sets enable, lock and flash-invalidate. A snoop port takes invalidate requests from the bus and reports hit or miss for each one. The data array, dirty write-back and coherence states other than valid are kept outside this block.

The address splits into tag, set index and line offset. A line is 16 bytes long and is refilled as four beats. When the cache is locked, hits are served as usual, but a miss becomes an uncached single-beat transfer and no line is allocated. A flash invalidate clears one set per clock. While it runs, CPU accesses stall and snoops report a miss.

Top module: `l1_tag_ctrl`

## Requirements
- R1: After a synchronous reset, stat_en, stat_lock, stat_flush, busy, cpu_stall, resp_valid, bus_req and snp_ack are all 0, and no line is valid.
- R2: With the enable bit 0, every accepted access gets resp_code 2 (single) and a bus request with bus_burst 0 and the full access address. No line is allocated, so the same address misses once the cache is enabled.
- R3: With the enable bit 0, a snoop is acknowledged one cycle later with snp_hit 0, and no valid bit changes.
- R4: On every bus request, bus_ci equals the cpu_ci that came with the access, whatever the enable and lock state. An access with cpu_ci 1 is always single-beat.
- R5: A cacheable miss while unlocked gives resp_code 1 (fill) and a bus request with bus_burst 1. The address is line-aligned (low 4 bits zero). cpu_stall stays high until refill_done pulses, and that pulse writes the victim way's tag and valid bit. Responses come one cycle after the access is accepted (cpu_req high while cpu_stall is low). resp_code 0 means a hit, and resp_way gives the hit or fill way.
- R6: A miss fills the lowest-numbered invalid way of its set. It uses the replacement victim only when all four ways are valid.
- R7: Each set has a 3-bit tree: bit 0 is the root, 0 selecting ways 0/1 and 1 selecting ways 2/3. Bit 1 picks way 1 over way 0 when set, and bit 2 picks way 3 over way 2 when set. A hit or fill on way w sets the root to the inverse of w[1] and the pair bit to the inverse of w[0].
- R8: With lock 1, a hit returns normally and updates the tree. A miss gives resp_code 2 with a single-beat request, and no line or tree changes.
- R9: A snoop that hits a valid line while enabled reports snp_hit 1 and clears that line, locked or not. While locked, the line stays invalid and accesses to it go single-beat.
- R10: A flash invalidate clears every valid bit and sets every tree to 0 (victim way 0), with no write-back.
- R11: A written flash bit reads 1 for one cycle and clears when the operation starts. If enabled, busy then stays high for exactly 16 cycles (one per set). If disabled, busy stays low and the lines are kept.
- R12: While busy, cpu_stall is 1, no access is accepted, and every snoop reports snp_hit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_en | input | 1 | Enable bit to write |
| cfg_lock | input | 1 | Lock bit to write |
| cfg_flush | input | 1 | Flash-invalidate bit to write |
| cpu_req | input | 1 | CPU access request |
| cpu_addr | input | 16 | CPU byte address |
| cpu_ci | input | 1 | Cache-inhibit attribute of the access |
| cpu_stall | output | 1 | Access not accepted this cycle |
| resp_valid | output | 1 | Decision valid (one cycle) |
| resp_code | output | 2 | 0 hit, 1 fill, 2 single |
| resp_way | output | 2 | Hit or fill way |
| bus_req | output | 1 | Bus transfer request (one cycle) |
| bus_burst | output | 1 | 1: four-beat line fill, 0: single beat |
| bus_ci | output | 1 | Cache-inhibit attribute sent to the bus |
| bus_addr | output | 16 | Bus transfer address |
| refill_done | input | 1 | Pulse when the line fill completes |
| snp_req | input | 1 | Snoop invalidate request |
| snp_addr | input | 16 | Snoop address |
| snp_ack | output | 1 | Snoop answered |
| snp_hit | output | 1 | Snoop found a valid line |
| busy | output | 1 | Flash invalidate in progress |
| stat_en | output | 1 | Enable bit readback |
| stat_lock | output | 1 | Lock bit readback |
| stat_flush | output | 1 | Flash bit readback |

## Verification
The hardest case to reach is a fully valid set whose victim comes from the tree and not from the invalid-first search. The bench sweeps all 16 sets with two tag sequences of different period, so each set cycles through more tags than it has ways and takes hits and evictions in a mixed order, and it tracks the expected tree state arithmetically. A snoop during a flash invalidate has to land in the 16-cycle busy window. The bench issues it on the first cycle busy is seen, aims it at a line that was valid just before, and holds a CPU request pending for the rest of the window.

// File: rtl/l1tag_pkg.sv
package l1tag_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [1:0] {
    RSP_HIT    = 2'd0,
    RSP_FILL   = 2'd1,
    RSP_SINGLE = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_FLUSH = 2'd2
  } st_e;

  // way selected by a 3-bit replacement tree
  function automatic logic [WAY_W-1:0] tree_victim(input logic [2:0] t);
    logic [WAY_W-1:0] w;
    w[1] = t[0];
    w[0] = t[0] ? t[2] : t[1];
    return w;
  endfunction

  // point the tree away from the way just used
  function automatic logic [2:0] tree_touch(input logic [2:0] t, input logic [WAY_W-1:0] w);
    logic [2:0] n;
    n    = t;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/l1tag_lookup.sv
module l1tag_lookup
  import l1tag_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            valid,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == tag);
  end

  always_comb begin
    way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) way = WAY_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/l1tag_victim.sv
module l1tag_victim
  import l1tag_pkg::*;
(
  input  logic [WAYS-1:0]  valid,
  input  logic [2:0]       tree,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    way = tree_victim(tree);
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/l1tag_store.sv
module l1tag_store
  import l1tag_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SET_W-1:0]           a_set,
  output logic [WAYS-1:0][TAG_W-1:0] a_tags,
  output logic [WAYS-1:0]            a_valid,
  output logic [2:0]                 a_tree,
  input  logic [SET_W-1:0]           b_set,
  output logic [WAYS-1:0][TAG_W-1:0] b_tags,
  output logic [WAYS-1:0]            b_valid,
  input  logic                       fill_we,
  input  logic [SET_W-1:0]           fill_set,
  input  logic [WAY_W-1:0]           fill_way,
  input  logic [TAG_W-1:0]           fill_tag,
  input  logic                       inv_we,
  input  logic [SET_W-1:0]           inv_set,
  input  logic [WAY_W-1:0]           inv_way,
  input  logic                       clr_we,
  input  logic [SET_W-1:0]           clr_set,
  input  logic                       lru_we,
  input  logic [SET_W-1:0]           lru_set,
  input  logic [WAY_W-1:0]           lru_way
);
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [2:0]                 tree_q  [SETS];

  // tag storage: no reset, plain write port
  always_ff @(posedge clk) begin
    if (fill_we) tag_q[fill_set][fill_way] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) begin
        valid_q[i] <= '0;
        tree_q[i]  <= '0;
      end
    end else begin
      if (fill_we) valid_q[fill_set][fill_way] <= 1'b1;
      if (inv_we)  valid_q[inv_set][inv_way]   <= 1'b0;
      if (lru_we)  tree_q[lru_set] <= tree_touch(tree_q[lru_set], lru_way);
      if (clr_we) begin
        valid_q[clr_set] <= '0;
        tree_q[clr_set]  <= '0;
      end
    end
  end

  assign a_tags  = tag_q[a_set];
  assign a_valid = valid_q[a_set];
  assign a_tree  = tree_q[a_set];
  assign b_tags  = tag_q[b_set];
  assign b_valid = valid_q[b_set];
endmodule

// File: rtl/l1_tag_ctrl.sv
module l1_tag_ctrl
  import l1tag_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic              cfg_lock,
  input  logic              cfg_flush,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_ci,
  output logic              cpu_stall,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic [1:0]        resp_way,
  output logic              bus_req,
  output logic              bus_burst,
  output logic              bus_ci,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              refill_done,
  input  logic              snp_req,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ack,
  output logic              snp_hit,
  output logic              busy,
  output logic              stat_en,
  output logic              stat_lock,
  output logic              stat_flush
);
  localparam int SET_W = $clog2(SETS);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;

  st_e st_q;
  logic en_q, lock_q, flush_q;
  logic [SET_W-1:0] walk_q;
  logic [SET_W-1:0] fset_q;
  logic [TAG_W-1:0] ftag_q;
  logic [WAY_W-1:0] fway_q;

  logic [SET_W-1:0] cpu_set, snp_set;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  logic [WAYS-1:0][TAG_W-1:0] a_tags, b_tags;
  logic [WAYS-1:0] a_valid, b_valid;
  logic [2:0] a_tree;
  logic a_hit, b_hit;
  logic [WAY_W-1:0] a_way, b_way, vic_way;
  logic accept, cacheable, do_hit, do_fill, fill_we, snp_inv, lru_we;
  logic [SET_W-1:0] lru_set;
  logic [WAY_W-1:0] lru_way;

  assign cpu_set = cpu_addr[OFF_W +: SET_W];
  assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign snp_set = snp_addr[OFF_W +: SET_W];
  assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];

  l1tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .a_set(cpu_set), .a_tags(a_tags), .a_valid(a_valid), .a_tree(a_tree),
    .b_set(snp_set), .b_tags(b_tags), .b_valid(b_valid),
    .fill_we(fill_we), .fill_set(fset_q), .fill_way(fway_q), .fill_tag(ftag_q),
    .inv_we(snp_inv), .inv_set(snp_set), .inv_way(b_way),
    .clr_we(st_q == ST_FLUSH), .clr_set(walk_q),
    .lru_we(lru_we), .lru_set(lru_set), .lru_way(lru_way)
  );

  l1tag_lookup #(.TAG_W(TAG_W)) u_cpu_look (
    .tags(a_tags), .valid(a_valid), .tag(cpu_tag), .hit(a_hit), .way(a_way)
  );

  l1tag_lookup #(.TAG_W(TAG_W)) u_snp_look (
    .tags(b_tags), .valid(b_valid), .tag(snp_tag), .hit(b_hit), .way(b_way)
  );

  l1tag_victim u_victim (
    .valid(a_valid), .tree(a_tree), .way(vic_way)
  );

  assign cpu_stall = (st_q != ST_IDLE) || flush_q;
  assign accept    = cpu_req && !cpu_stall;
  assign cacheable = en_q && !cpu_ci;
  assign do_hit    = accept && cacheable && a_hit;
  assign do_fill   = accept && cacheable && !a_hit && !lock_q;
  assign fill_we   = (st_q == ST_FILL) && refill_done;
  assign snp_inv   = snp_req && en_q && (st_q != ST_FLUSH) && b_hit;
  assign lru_we    = do_hit || fill_we;
  assign lru_set   = do_hit ? cpu_set : fset_q;
  assign lru_way   = do_hit ? a_way : fway_q;

  // control register and sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      lock_q  <= 1'b0;
      flush_q <= 1'b0;
      st_q    <= ST_IDLE;
      walk_q  <= '0;
    end else begin
      if (cfg_we) begin
        en_q    <= cfg_en;
        lock_q  <= cfg_lock;
        flush_q <= cfg_flush;
      end else if (flush_q && st_q == ST_IDLE) begin
        flush_q <= 1'b0;
      end
      case (st_q)
        ST_IDLE: begin
          if (flush_q && en_q) begin
            st_q   <= ST_FLUSH;
            walk_q <= '0;
          end else if (do_fill) begin
            st_q <= ST_FILL;
          end
        end
        ST_FILL: if (refill_done) st_q <= ST_IDLE;
        ST_FLUSH: begin
          walk_q <= walk_q + 1'b1;
          if (walk_q == SET_W'(SETS - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // fill bookkeeping
  always_ff @(posedge clk) begin
    if (do_fill) begin
      fset_q <= cpu_set;
      ftag_q <= cpu_tag;
      fway_q <= vic_way;
    end
  end

  // registered responses
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_code  <= RSP_HIT;
      resp_way   <= '0;
      bus_req    <= 1'b0;
      bus_burst  <= 1'b0;
      bus_ci     <= 1'b0;
      bus_addr   <= '0;
      snp_ack    <= 1'b0;
      snp_hit    <= 1'b0;
    end else begin
      resp_valid <= accept;
      bus_req    <= accept && !do_hit;
      snp_ack    <= snp_req;
      snp_hit    <= snp_inv;
      if (accept) begin
        bus_ci    <= cpu_ci;
        bus_burst <= do_fill;
        if (do_hit) begin
          resp_code <= RSP_HIT;
          resp_way  <= a_way;
        end else if (do_fill) begin
          resp_code <= RSP_FILL;
          resp_way  <= vic_way;
          bus_addr  <= {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end else begin
          resp_code <= RSP_SINGLE;
          resp_way  <= '0;
          bus_addr  <= cpu_addr;
        end
      end
    end
  end

  assign busy       = (st_q == ST_FLUSH);
  assign stat_en    = en_q;
  assign stat_lock  = lock_q;
  assign stat_flush = flush_q;
endmodule

// File: rtl/l1tag_ctrl_chk.sv
module l1tag_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int SETS   = 16,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ci,
  input logic              cpu_stall,
  input logic              resp_valid,
  input logic [1:0]        resp_code,
  input logic              bus_req,
  input logic              bus_burst,
  input logic              bus_ci,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_ack,
  input logic              snp_hit,
  input logic              busy,
  input logic              stat_en,
  input logic              stat_flush
);
  localparam int RUN_W = $clog2(SETS) + 2;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R2
  disabled_single_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !$past(stat_en) |-> resp_code == 2'd2);
  // R3
  disabled_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    snp_ack && !$past(stat_en) |-> !snp_hit);
  // R4
  ci_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_ci == $past(cpu_ci));
  // R5
  fill_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_burst |-> bus_addr[OFF_W-1:0] == '0);
  // R5
  fill_stall_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_burst |-> cpu_stall);
  // R11
  flush_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stat_flush));
  // R11
  flush_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_q < RUN_W'(SETS));
  // R11
  flush_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_q == RUN_W'(SETS));
  // R12
  flush_stall_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> cpu_stall);
  // R12
  flush_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    snp_ack && $past(busy) |-> !snp_hit);
endmodule

bind l1_tag_ctrl l1tag_ctrl_chk #(
  .ADDR_W(ADDR_W), .SETS(SETS), .OFF_W($clog2(LINE_BYTES))
) u_chk (
  .clk(clk), .rst(rst), .cpu_ci(cpu_ci), .cpu_stall(cpu_stall),
  .resp_valid(resp_valid), .resp_code(resp_code), .bus_req(bus_req),
  .bus_burst(bus_burst), .bus_ci(bus_ci), .bus_addr(bus_addr),
  .snp_ack(snp_ack), .snp_hit(snp_hit), .busy(busy),
  .stat_en(stat_en), .stat_flush(stat_flush)
);

// File: tb/l1_tag_ctrl_tb.sv
module l1_tag_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_en = 0, cfg_lock = 0, cfg_flush = 0;
  logic cpu_req = 0, cpu_ci = 0, refill_done = 0, snp_req = 0;
  logic [15:0] cpu_addr = '0, snp_addr = '0;
  logic cpu_stall, resp_valid, bus_req, bus_burst, bus_ci, snp_ack, snp_hit, busy;
  logic stat_en, stat_lock, stat_flush;
  logic [1:0] resp_code, resp_way;
  logic [15:0] bus_addr;

  int checks = 0;
  int fails  = 0;

  bit       m_en = 0, m_lock = 0;
  bit       mv [16][4];
  bit [7:0] mt [16][4];
  bit [2:0] mp [16];

  always #2 clk = ~clk;

  l1_tag_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_lock(cfg_lock),
    .cfg_flush(cfg_flush), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ci(cpu_ci),
    .cpu_stall(cpu_stall), .resp_valid(resp_valid), .resp_code(resp_code),
    .resp_way(resp_way), .bus_req(bus_req), .bus_burst(bus_burst), .bus_ci(bus_ci),
    .bus_addr(bus_addr), .refill_done(refill_done), .snp_req(snp_req),
    .snp_addr(snp_addr), .snp_ack(snp_ack), .snp_hit(snp_hit), .busy(busy),
    .stat_en(stat_en), .stat_lock(stat_lock), .stat_flush(stat_flush)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 16; s++) begin
      mp[s] = 3'd0;
      for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
    end
  endtask

  function automatic int find_way(input int s, input bit [7:0] t);
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int pick_victim(input int s);
    for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
    if (mp[s][0] == 1'b0) return mp[s][1] ? 1 : 0;
    return mp[s][2] ? 3 : 2;
  endfunction

  task automatic touch(input int s, input int w);
    mp[s][0] = (w < 2);
    if (w < 2) mp[s][1] = (w == 0);
    else       mp[s][2] = (w == 2);
  endtask

  task automatic cfg_write(input bit en, input bit lock, input bit fl);
    @(negedge clk);
    cfg_we = 1; cfg_en = en; cfg_lock = lock; cfg_flush = fl;
    @(negedge clk);
    cfg_we = 0; cfg_flush = 0;
    m_en = en; m_lock = lock;
  endtask

  task automatic do_access(input bit [7:0] t, input int s, input bit ci);
    int hw, exp_code, exp_way;
    string req;
    bit [15:0] a;
    a = {t, 4'(s), 4'h6};
    hw = find_way(s, t);
    exp_way = 0;
    if (!m_en)            begin exp_code = 2; req = "R2"; end
    else if (ci)          begin exp_code = 2; req = "R4"; end
    else if (hw >= 0)     begin exp_code = 0; exp_way = hw; req = m_lock ? "R8" : "R7"; end
    else if (m_lock)      begin exp_code = 2; req = "R8"; end
    else                  begin exp_code = 1; exp_way = pick_victim(s); req = "R6"; end
    @(negedge clk);
    cpu_req = 1; cpu_addr = a; cpu_ci = ci;
    while (cpu_stall) @(negedge clk);
    @(negedge clk);
    cpu_req = 0;
    chk(resp_valid == 1'b1, "R5", "resp_valid", int'(resp_valid), 1);
    chk(resp_code == 2'(exp_code), req, "resp_code", int'(resp_code), exp_code);
    if (exp_code != 2) chk(resp_way == 2'(exp_way), req, "resp_way", int'(resp_way), exp_way);
    chk(bus_req == (exp_code != 0), req, "bus_req", int'(bus_req), int'(exp_code != 0));
    chk(bus_ci == ci, "R4", "bus_ci", int'(bus_ci), int'(ci));
    if (exp_code == 2) begin
      chk(bus_burst == 1'b0, req, "bus_burst", int'(bus_burst), 0);
      chk(bus_addr == a, req, "bus_addr", int'(bus_addr), int'(a));
    end
    if (exp_code == 1) begin
      chk(bus_burst == 1'b1, "R5", "bus_burst", int'(bus_burst), 1);
      chk(bus_addr == {a[15:4], 4'h0}, "R5", "bus_addr", int'(bus_addr), int'({a[15:4], 4'h0}));
      chk(cpu_stall == 1'b1, "R5", "stall before refill", int'(cpu_stall), 1);
      refill_done = 1;
      @(negedge clk);
      refill_done = 0;
      chk(cpu_stall == 1'b0, "R5", "stall after refill", int'(cpu_stall), 0);
      mv[s][exp_way] = 1'b1;
      mt[s][exp_way] = t;
      touch(s, exp_way);
    end
    if (exp_code == 0) touch(s, hw);
  endtask

  task automatic do_snoop(input bit [7:0] t, input int s);
    int hw;
    bit exp;
    hw = find_way(s, t);
    exp = m_en && (hw >= 0);
    @(negedge clk);
    snp_req = 1; snp_addr = {t, 4'(s), 4'h0};
    @(negedge clk);
    snp_req = 0;
    chk(snp_ack == 1'b1, m_en ? "R9" : "R3", "snp_ack", int'(snp_ack), 1);
    chk(snp_hit == exp, m_en ? "R9" : "R3", "snp_hit", int'(snp_hit), int'(exp));
    if (exp) mv[s][hw] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(stat_en == 0 && stat_lock == 0 && stat_flush == 0, "R1", "ctrl bits", int'({stat_en, stat_lock, stat_flush}), 0);
    chk(busy == 0 && cpu_stall == 0, "R1", "busy/stall", int'({busy, cpu_stall}), 0);
    chk(resp_valid == 0 && bus_req == 0 && snp_ack == 0, "R1", "pulses", int'({resp_valid, bus_req, snp_ack}), 0);

    // R2 / R3 / R4 while disabled
    for (int s = 0; s < 16; s += 3) begin
      do_access(8'h21, s, 1'b0);
      do_access(8'h22, s, 1'b1);
      do_snoop(8'h21, s);
    end

    // enable, sweep all sets with two tag patterns
    cfg_write(1, 0, 0);
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 10; k++) do_access(8'h10 + 8'((k * 3) % 7), s, (k % 7) == 6);
      for (int k = 0; k < 10; k++) do_access(8'h10 + 8'(k % 5), s, 1'b0);
    end
    // the disabled-mode addresses were never allocated (R2): set 0 gets tag 8'h21 fresh
    do_access(8'h21, 0, 1'b0);

    // snoops while enabled, some present some absent (R9)
    for (int s = 0; s < 16; s += 2) begin
      do_snoop(8'h10 + 8'(s % 5), s);
      do_snoop(8'h7f, s);
    end

    // lock mode (R8, R9)
    cfg_write(1, 1, 0);
    for (int k = 0; k < 6; k++) do_access(8'h10 + 8'(k), 5, 1'b0);
    do_snoop(8'h14, 5);
    do_access(8'h14, 5, 1'b0);
    do_access(8'h14, 5, 1'b0);
    do_access(8'h14, 5, 1'b1);
    cfg_write(1, 0, 0);
    do_access(8'h14, 5, 1'b0);
    do_access(8'h14, 5, 1'b0);

    // flash invalidate while enabled (R10, R11, R12)
    cfg_write(1, 0, 1);
    chk(stat_flush == 1'b1, "R11", "flush bit set", int'(stat_flush), 1);
    chk(busy == 1'b0, "R11", "busy before start", int'(busy), 0);
    cpu_req = 1; cpu_addr = {8'h14, 4'd5, 4'h0}; cpu_ci = 0;
    @(negedge clk);
    chk(stat_flush == 1'b0, "R11", "flush bit self-clear", int'(stat_flush), 1'b0);
    n = 0;
    while (busy && n < 40) begin
      chk(cpu_stall == 1'b1, "R12", "stall in flush", int'(cpu_stall), 1);
      chk(resp_valid == 1'b0, "R12", "no accept in flush", int'(resp_valid), 0);
      if (n == 0) begin snp_req = 1; snp_addr = {8'h14, 4'd5, 4'h0}; end
      if (n == 1) chk(snp_ack == 1'b1 && snp_hit == 1'b0, "R12", "snoop miss in flush", int'({snp_ack, snp_hit}), 2);
      n++;
      @(negedge clk);
      snp_req = 0;
    end
    cpu_req = 0;
    chk(n == 16, "R11", "busy cycles", n, 16);
    model_clear();
    for (int s = 0; s < 16; s++) do_access(8'h10, s, 1'b0);
    for (int k = 1; k < 6; k++) do_access(8'h10 + 8'(k), 9, 1'b0);

    // flash request while disabled: no operation, lines kept (R11)
    cfg_write(0, 0, 1);
    chk(stat_flush == 1'b1, "R11", "flush bit set disabled", int'(stat_flush), 1);
    @(negedge clk);
    chk(stat_flush == 1'b0 && busy == 1'b0, "R11", "disabled flush idle", int'({stat_flush, busy}), 0);
    cfg_write(1, 0, 0);
    for (int s = 0; s < 16; s++) do_access(8'h10, s, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule